// File: doc/BRIEF.md
# Shift-Register Tapped FIFO

This block is a small single-clock FIFO whose storage is a chain of registers that shift, not a ring addressed by two pointers. An accepted push loads the incoming word into the first stage and moves every stored word one stage further along the chain. The write position therefore never moves. An up/down occupancy counter serves as the read address. It selects the tap at stage count-1, which always holds the oldest word, and that tap drives the output.

The output path is a single tap multiplexer fed by a registered count, so the read side stays shallow enough for clock rates of 200 MHz and above. Full and empty are decoded from that registered count. The block suits short elasticity buffers, where a push and a pop may come in the same cycle and the occupancy is then unchanged.

Top module: `srfifo_top`

## Requirements
- R1: After synchronous reset the count is 0, empty is 1 and full is 0.
- R2: A push without a pop, when not full, raises the count by one on the next clock edge.
- R3: A pop without a push, when not empty, lowers the count by one on the next clock edge.
- R4: A push and a pop in the same cycle, when not empty, leave the count unchanged. The output then shows the word that was second oldest, or the pushed word if one word was stored.
- R5: While not empty, the data output is the oldest stored word, so words leave in the order they were pushed.
- R6: empty is 1 exactly when the count is 0, and full is 1 exactly when the count equals DEPTH (default 16).
- R7: A push while full has no effect: the count stays at DEPTH and the stored words and their order are unchanged.
- R8: A pop while empty has no effect: the count stays at 0.
- R9: A push and a pop together while empty act as a push alone, so the count becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| pop | input | 1 | Read request (the current output word is consumed) |
| din | input | WIDTH | Data to write |
| dout | output | WIDTH | Oldest stored word; don't-care while empty |
| full | output | 1 | Count equals DEPTH |
| empty | output | 1 | Count equals zero |
| count | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
Every result is due one clock edge after the request that causes it. Count, full and empty change at that edge. dout shows the new oldest word straight after the same edge, because dout is only a tap multiplexer on the registered count. The bench drives its inputs at the falling edge. It updates a queue model at the rising edge, using the inputs it drove. It compares count, flags and, when the FIFO is not empty, dout at the next falling edge, after the design has settled. Directed phases cover fill to full, pushes while full, drain to empty, pops while empty, simultaneous push and pop at one, at several and at zero words, and a random mix.

// File: rtl/srfifo_pkg.sv
package srfifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } op_e;
endpackage

// File: rtl/srfifo_ctrl.sv
module srfifo_ctrl
  import srfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic          shift_en,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  logic acc_push, acc_pop;
  op_e  op;

  assign full     = (count == DEPTH_C);
  assign empty    = (count == '0);
  assign acc_pop  = pop & ~empty;
  // a push while full is refused, unless a pop makes room in the same cycle
  assign acc_push = push & (~full | acc_pop);
  assign op       = op_e'({acc_push, acc_pop});
  assign shift_en = acc_push;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      unique case (op)
        OP_PUSH: count <= count + 1'b1;
        OP_POP:  count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/srfifo_chain.sv
module srfifo_chain #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] taps [DEPTH]
);
  always_ff @(posedge clk) begin
    if (en) taps[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (en) taps[i] <= taps[i-1];
    end
  end
endmodule

// File: rtl/srfifo_tapsel.sv
module srfifo_tapsel #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [WIDTH-1:0] taps [DEPTH],
  input  logic [CW-1:0]    count,
  output logic [WIDTH-1:0] dout
);
  always_comb begin
    dout = taps[0];
    for (int i = 1; i < DEPTH; i++) begin
      if (count == CW'(i + 1)) dout = taps[i];
    end
  end
endmodule

// File: rtl/srfifo_top.sv
module srfifo_top #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic             shift_en;
  logic [WIDTH-1:0] taps [DEPTH];

  srfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .shift_en(shift_en), .count(count), .full(full), .empty(empty)
  );

  srfifo_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
    .clk(clk), .en(shift_en), .din(din), .taps(taps)
  );

  srfifo_tapsel #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tapsel (
    .taps(taps), .count(count), .dout(dout)
  );
endmodule

// File: rtl/srfifo_chk.sv
module srfifo_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             push,
  input logic             pop,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] dout,
  input logic             full,
  input logic             empty,
  input logic [CW-1:0]    count
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (count == '0 && empty && !full));
  // R2
  push_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full) |=> count == $past(count) + 1'b1);
  // R3
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !empty) |=> count == $past(count) - 1'b1);
  // R4
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty) |=> $stable(count));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH));
  // R7
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(dout)));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
  // R9
  empty_both_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && push && pop) |=> (count == CW'(1) && dout == $past(din)));
endmodule

bind srfifo_top srfifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/srfifo_top_bench.sv
`timescale 1ns/1ps
module srfifo_top_bench;
  localparam int WIDTH = 16;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1, push = 1'b0, pop = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic full, empty;
  logic [CW-1:0] count;

  int n_chk = 0, n_bad = 0;
  logic [WIDTH-1:0] model [$];
  string tag = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  srfifo_top #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_srfifo_top (.*);

  // reference model: updated at rising edge from the driven inputs
  always @(posedge clk) begin
    if (rst) model.delete();
    else begin
      automatic bit p = push, q = pop;
      automatic int n = model.size();
      if (q && n > 0) void'(model.pop_front());
      if (p && (n < DEPTH || (q && n > 0))) model.push_back(din);
    end
  end

  task automatic compare();
    automatic int n = model.size();
    n_chk++;
    if (count != CW'(n) || empty != (n == 0) || full != (n == DEPTH)) begin
      n_bad++;
      $display("FAIL %s: count/empty/full=%0d/%0b/%0b expected %0d/%0b/%0b",
               tag, count, empty, full, n, n == 0, n == DEPTH);
    end
    if (n > 0) begin
      n_chk++;
      if (dout != model[0]) begin
        n_bad++;
        $display("FAIL %s: dout=%h expected %h", tag, dout, model[0]);
      end
    end
  endtask

  always @(negedge clk) if (!done) compare();

  task automatic step(bit p, bit q, logic [WIDTH-1:0] d);
    @(negedge clk);
    push = p; pop = q; din = d;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;                                   // R1 checked on the cycles above
    tag = "R2"; for (int i = 0; i < DEPTH; i++) step(1, 0, 16'h1000 + 16'(i));
    tag = "R7"; for (int i = 0; i < 4; i++) step(1, 0, 16'hDEAD);
    tag = "R4"; for (int i = 0; i < 3; i++) step(1, 1, 16'h2000 + 16'(i)); // at full
    tag = "R5"; for (int i = 0; i < DEPTH; i++) step(0, 1, '0);            // R3 drain
    tag = "R8"; for (int i = 0; i < 3; i++) step(0, 1, '0);
    tag = "R9"; step(1, 1, 16'hBEEF);
    tag = "R4"; for (int i = 0; i < 4; i++) step(1, 1, 16'h3000 + 16'(i)); // at one word
    tag = "R3"; step(0, 1, '0);
    tag = "R6"; step(1, 0, 16'h4001); step(1, 0, 16'h4002); step(1, 0, 16'h4003);
    for (int i = 0; i < 3; i++) step(1, 1, 16'h5000 + 16'(i));
    tag = "R5";
    for (int i = 0; i < 3000; i++) step(1'($urandom), 1'($urandom), 16'($urandom));
    tag = "R1"; step(0, 0, '0); rst = 1'b1; step(0, 0, '0); rst = 1'b0;
    step(0, 0, '0);
    @(negedge clk); done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule